// File: doc/BRIEF.md
# Dual-Order Sigma-Delta Bitstream Shaper

This block turns one channel of oversampled, signed 24-bit audio into a 1-bit bitstream for a semi-digital reconstruction DAC. A chain of saturating integrators shapes the quantisation noise toward high frequencies. Each accepted sample yields one output bit. The bit is the sign of the last integrator in use, and the loop subtracts plus or minus full scale as feedback.

Two loop configurations share the same integrator chain. The third-order loop is meant for low sample rates, roughly 8 to 16 kHz, and runs at 128 times the sample rate. The fifth-order loop is meant for 32 kHz and above, and runs at 64 times the sample rate. The block does not generate the oversampled clock. It reports which reconstruction filter and clock rate match the active loop order, so the DAC can follow the order.

A new order is taken only when no sample is presented in that cycle or while the channel is muted, and every change starts the loop from a cleared state. A monitor counts how long the loop has been saturated. If the saturation lasts too long, the monitor restarts the loop and raises a sticky warning.

Top module: `dsm_dual_shaper`

## Requirements
- R1: After reset: `bit_out`=0, `bit_valid`=0, `unstable`=0, `order_o`=0 (third order) and `rate_sel`=1.
- R2: `bit_valid` is high exactly in the cycle after a cycle in which `in_valid` was high and no order change was taken. `bit_out` changes only in such cycles.
- R3: The output bit of a sample is 1 when the last active integrator, read before that sample's update, is zero or positive, and 0 when it is negative. The feedback value is +2^(IN_W-1) for a 1 and -2^(IN_W-1) for a 0.
- R4: Integrators are W=IN_W+GUARD bits wide, and all of them update at once from their old values. Stage 1 adds the input and subtracts the feedback. Stage k≥2 adds stage k-1 shifted arithmetically right by A_SH and subtracts the feedback shifted arithmetically right by FB_SH. Each result is clipped to the signed W-bit range and never wraps.
- R5: `order_o`=0 selects third order, using stages 1–3 with stage 3 as output, and sets `rate_sel`=1 (128× filter). `order_o`=1 selects fifth order, using stages 1–5 with stage 5 as output, and sets `rate_sel`=0 (64× filter). Unused stages hold their value.
- R6: `mode_sel` is taken into `order_o` only in a cycle where `mute` is high or `in_valid` is low. It is ignored in a cycle where `in_valid` is high and `mute` is low.
- R7: A cycle in which a new order is taken clears every integrator and the saturation count. No sample is processed in that cycle.
- R8: While `mute` is high, the loop input is treated as zero, whatever value `in_sample` carries.
- R9: An update in which any active stage clips counts as saturated. The (SAT_LIMIT+1)-th consecutive saturated update clears all integrators and the count, and sets `unstable`. `unstable` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the oversampled rate |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | IN_W | Signed two's-complement input sample |
| mode_sel | input | 1 | Requested order: 0 third, 1 fifth |
| mute | input | 1 | Forces zero input and permits order change |
| bit_out | output | 1 | Shaped 1-bit output |
| bit_valid | output | 1 | Strobe for `bit_out` |
| order_o | output | 1 | Active order: 0 third, 1 fifth |
| rate_sel | output | 1 | Matching DAC filter: 1 for 128×, 0 for 64× |
| unstable | output | 1 | Sticky loop-overload flag |

## Verification
The bench builds the block with IN_W=24, two guard bits and SAT_LIMIT=8, and keeps both shift values at 1. With only two guard bits, a near-full-scale input drives the fifth-order loop into clipping within a few hundred samples. The short limit means the instability trip, the restart and the sticky flag all occur inside a brief directed run. A bit-exact reference of the update equations tracks every output bit, so any clipping, switching or restart error shows up as a divergence in the bitstream.

// File: rtl/dsm_pkg.sv
// Shared types for the dual-order shaper.
// Assumes: one bit is enough to encode the loop order.
package dsm_pkg;
    typedef enum logic {
        ORD_THIRD = 1'b0,
        ORD_FIFTH = 1'b1
    } dsm_order_e;
endpackage

// File: rtl/dsm_integ.sv
// One saturating integrator stage: state += add_v - sub_v, clipped to W bits.
// Assumes: clr has priority over en; sat_o reports clipping of the candidate value.
module dsm_integ #(
    parameter int W = 26
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                clr,
    input  logic signed [W-1:0] add_v,
    input  logic signed [W-1:0] sub_v,
    output logic signed [W-1:0] st_o,
    output logic                sat_o
);
    localparam logic signed [W+1:0] MAXV = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [W+1:0] MINV = {3'b111, {(W-1){1'b0}}};

    logic signed [W+1:0] sum;
    logic signed [W-1:0] clipped;

    // Wide sum and clip to the W-bit range.
    always_comb begin
        sum = {{2{st_o[W-1]}}, st_o} + {{2{add_v[W-1]}}, add_v} - {{2{sub_v[W-1]}}, sub_v};
        sat_o = 1'b0;
        clipped = sum[W-1:0];
        if (sum > MAXV) begin
            clipped = MAXV[W-1:0];
            sat_o = 1'b1;
        end else if (sum < MINV) begin
            clipped = MINV[W-1:0];
            sat_o = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)   st_o <= '0;
        else if (clr) st_o <= '0;
        else if (en)  st_o <= clipped;
    end
endmodule

// File: rtl/dsm_loop.sv
// Integrator chain shared by both orders, with sign feedback.
// Assumes: GUARD >= 1 so full scale fits; ORD_LO < ORD_HI; stages above ORD_LO idle in low order.
module dsm_loop #(
    parameter int IN_W   = 24,
    parameter int GUARD  = 4,
    parameter int A_SH   = 1,
    parameter int FB_SH  = 1,
    parameter int ORD_LO = 3,
    parameter int ORD_HI = 5,
    localparam int W     = IN_W + GUARD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd,
    input  logic                   clr,
    input  logic                   ord_hi,
    input  logic signed [IN_W-1:0] u,
    input  logic                   y_fb,
    output logic signed [W-1:0]    x_last,
    output logic                   sat_any
);
    localparam logic signed [W-1:0] FS_POS = {{GUARD{1'b0}}, 1'b1, {(IN_W-1){1'b0}}};
    localparam logic signed [W-1:0] FS_NEG = {{(GUARD+1){1'b1}}, {(IN_W-1){1'b0}}};

    logic signed [W-1:0] st [ORD_HI];
    logic [ORD_HI-1:0]   sat_v;
    logic signed [W-1:0] fb_full;
    logic signed [W-1:0] fb_part;
    logic signed [W-1:0] u_ext;

    // Feedback and input scaling.
    always_comb begin
        fb_full = y_fb ? FS_POS : FS_NEG;
        fb_part = fb_full >>> FB_SH;
        u_ext   = {{GUARD{u[IN_W-1]}}, u};
    end

    for (genvar k = 0; k < ORD_HI; k++) begin : g_stage
        logic signed [W-1:0] add_k;
        logic signed [W-1:0] sub_k;
        logic                en_k;
        logic                sat_k;
        if (k == 0) begin : g_first
            assign add_k = u_ext;
            assign sub_k = fb_full;
        end else begin : g_rest
            assign add_k = st[k-1] >>> A_SH;
            assign sub_k = fb_part;
        end
        if (k < ORD_LO) begin : g_always
            assign en_k = upd;
        end else begin : g_high
            assign en_k = upd & ord_hi;
        end
        dsm_integ #(.W(W)) u_int (
            .clk(clk), .rst_n(rst_n), .en(en_k), .clr(clr),
            .add_v(add_k), .sub_v(sub_k), .st_o(st[k]), .sat_o(sat_k)
        );
        assign sat_v[k] = sat_k & en_k;
    end

    // Output stage selection and clip summary.
    always_comb begin
        x_last  = ord_hi ? st[ORD_HI-1] : st[ORD_LO-1];
        sat_any = |sat_v;
    end
endmodule

// File: rtl/dsm_mode_ctrl.sv
// Holds the active loop order and takes a new one only when idle or muted.
// Assumes: chg is a combinational strobe used by the same cycle's clear.
module dsm_mode_ctrl
    import dsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    input  logic       in_valid,
    input  logic       mute,
    output dsm_order_e order,
    output logic       chg
);
    // Change is allowed with no sample present or while muted.
    always_comb chg = (mute || !in_valid) && (mode_sel != logic'(order));

    // Order register.
    always_ff @(posedge clk) begin
        if (!rst_n)   order <= ORD_THIRD;
        else if (chg) order <= dsm_order_e'(mode_sel);
    end
endmodule

// File: rtl/dsm_stab_mon.sv
// Counts consecutive saturated updates and trips the loop restart.
// Assumes: CW holds SAT_LIMIT; trip is a combinational strobe.
module dsm_stab_mon #(
    parameter int SAT_LIMIT = 64,
    parameter int CW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          clr,
    input  logic          sat_any,
    output logic          trip,
    output logic          unstable,
    output logic [CW-1:0] cnt
);
    // Trip on the update that would exceed the limit.
    always_comb trip = upd && sat_any && (cnt == CW'(SAT_LIMIT));

    // Run-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (upd) begin
            if (!sat_any || trip) cnt <= '0;
            else                  cnt <= cnt + CW'(1);
        end
    end

    // Sticky overload flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    unstable <= 1'b0;
        else if (trip) unstable <= 1'b1;
    end
endmodule

// File: rtl/dsm_dual_shaper.sv
// Top: one-channel noise shaper, third or fifth order, 1-bit output.
// Assumes: one sample per in_valid at the oversampled rate; mode_sel 0 = third.
module dsm_dual_shaper
    import dsm_pkg::*;
#(
    parameter int IN_W      = 24,
    parameter int GUARD     = 4,
    parameter int A_SH      = 1,
    parameter int FB_SH     = 1,
    parameter int ORD_LO    = 3,
    parameter int ORD_HI    = 5,
    parameter int SAT_LIMIT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_sample,
    input  logic            mode_sel,
    input  logic            mute,
    output logic            bit_out,
    output logic            bit_valid,
    output logic            order_o,
    output logic            rate_sel,
    output logic            unstable
);
    localparam int ST_W  = IN_W + GUARD;
    localparam int CNT_W = $clog2(SAT_LIMIT + 1);

    dsm_order_e             order;
    logic                   chg;
    logic                   upd;
    logic                   trip;
    logic                   sat_any;
    logic                   y;
    logic signed [IN_W-1:0] u;
    logic signed [ST_W-1:0] x_last;
    logic [CNT_W-1:0]       sat_cnt;

    dsm_mode_ctrl u_mode (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
        .mute(mute), .order(order), .chg(chg)
    );

    // Sample acceptance, muting and quantiser.
    always_comb begin
        upd = in_valid && !chg;
        u   = mute ? '0 : $signed(in_sample);
        y   = ~x_last[ST_W-1];
    end

    dsm_loop #(
        .IN_W(IN_W), .GUARD(GUARD), .A_SH(A_SH), .FB_SH(FB_SH),
        .ORD_LO(ORD_LO), .ORD_HI(ORD_HI)
    ) u_loop (
        .clk(clk), .rst_n(rst_n), .upd(upd), .clr(chg || trip),
        .ord_hi(order == ORD_FIFTH), .u(u), .y_fb(y),
        .x_last(x_last), .sat_any(sat_any)
    );

    dsm_stab_mon #(.SAT_LIMIT(SAT_LIMIT), .CW(CNT_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .upd(upd), .clr(chg), .sat_any(sat_any),
        .trip(trip), .unstable(unstable), .cnt(sat_cnt)
    );

    // Output bit register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= upd;
            if (upd) bit_out <= y;
        end
    end

    // Order and matching filter rate.
    always_comb begin
        order_o  = logic'(order);
        rate_sel = (order == ORD_THIRD);
    end
endmodule

// File: rtl/dsm_dual_shaper_chk.sv
// Checker for the shaper, attached by bind.
// Assumes: sat_cnt and last_st are the top's internal count and output stage.
module dsm_dual_shaper_chk #(
    parameter int W         = 28,
    parameter int CW        = 7,
    parameter int SAT_LIMIT = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                mute,
    input logic                bit_out,
    input logic                bit_valid,
    input logic                order_o,
    input logic                unstable,
    input logic signed [W-1:0] last_st,
    input logic [CW-1:0]       sat_cnt
);
    a_r6_order_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute) |=> $stable(order_o));

    a_r2_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(in_valid));

    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(bit_out));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unstable |=> unstable);

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sat_cnt <= CW'(SAT_LIMIT));

    a_r7_cleared_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (order_o != $past(order_o)) |-> (last_st == '0));
endmodule

bind dsm_dual_shaper dsm_dual_shaper_chk #(
    .W(ST_W), .CW(CNT_W), .SAT_LIMIT(SAT_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mute(mute),
    .bit_out(bit_out), .bit_valid(bit_valid), .order_o(order_o),
    .unstable(unstable), .last_st(x_last), .sat_cnt(sat_cnt)
);

// File: tb/sim_dsm_dual_shaper.sv
`timescale 1ns/1ps
module sim_dsm_dual_shaper;
    localparam int IN_W  = 24;
    localparam int GUARD = 2;
    localparam int A_SH  = 1;
    localparam int FB_SH = 1;
    localparam int LIM   = 8;
    localparam int W     = IN_W + GUARD;
    localparam longint FS   = longint'(1) <<< (IN_W - 1);
    localparam longint MAXV = (longint'(1) <<< (W - 1)) - 1;
    localparam longint MINV = -(longint'(1) <<< (W - 1));

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_sample = '0;
    logic            mode_sel = 1'b0;
    logic            mute = 1'b0;
    logic            bit_out, bit_valid, order_o, rate_sel, unstable;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] lf = 32'h1ACE_0F35;

    // Reference state.
    longint mx [5];
    int     m_cnt;
    logic   m_ord, m_unst, m_bit, m_valid;

    dsm_dual_shaper #(
        .IN_W(IN_W), .GUARD(GUARD), .A_SH(A_SH), .FB_SH(FB_SH),
        .ORD_LO(3), .ORD_HI(5), .SAT_LIMIT(LIM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .mode_sel(mode_sel), .mute(mute), .bit_out(bit_out), .bit_valid(bit_valid),
        .order_o(order_o), .rate_sel(rate_sel), .unstable(unstable)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint clip(input longint v, output logic s);
        s = 1'b0;
        if (v > MAXV) begin s = 1'b1; return MAXV; end
        if (v < MINV) begin s = 1'b1; return MINV; end
        return v;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 5; k++) mx[k] = 0;
        m_cnt = 0;
    endtask

    // Reference of R3-R9 for one clock edge.
    task automatic model_edge(input logic iv, input longint s, input logic ms, input logic mt);
        longint nx [5];
        longint f, u, last;
        logic sa, st;
        int top;
        m_valid = 1'b0;
        if ((mt || !iv) && (ms != m_ord)) begin
            m_ord = ms;
            model_clear();
        end else if (iv) begin
            top  = m_ord ? 5 : 3;
            last = mx[top-1];
            m_bit = (last >= 0);
            f = m_bit ? FS : -FS;
            u = mt ? 0 : s;
            sa = 1'b0;
            for (int k = 0; k < 5; k++) nx[k] = mx[k];
            for (int k = 0; k < top; k++) begin
                if (k == 0) nx[0] = clip(mx[0] + u - f, st);
                else        nx[k] = clip(mx[k] + (mx[k-1] >>> A_SH) - (f >>> FB_SH), st);
                sa = sa | st;
            end
            if (sa && m_cnt == LIM) begin
                model_clear();
                m_unst = 1'b1;
            end else begin
                m_cnt = sa ? m_cnt + 1 : 0;
                for (int k = 0; k < 5; k++) mx[k] = nx[k];
            end
            m_valid = 1'b1;
        end
    endtask

    // One cycle: drive, model, compare away from the edge.
    task automatic step(input logic iv, input longint s, input logic ms, input logic mt, input string tag);
        @(negedge clk);
        in_valid = iv; in_sample = IN_W'(s); mode_sel = ms; mute = mt;
        @(posedge clk);
        model_edge(iv, s, ms, mt);
        #1;
        chk({tag, " R2 valid"}, bit_valid, m_valid);
        if (m_valid) chk({tag, " R3 bit"}, bit_out, m_bit);
        chk({tag, " R9 unstable"}, unstable, m_unst);
        chk({tag, " R6 order"}, order_o, m_ord);
        chk({tag, " R5 rate"}, rate_sel, !m_ord);
    endtask

    function automatic longint rnd();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return longint'($signed(lf[IN_W-1:0])) >>> 2;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear(); m_ord = 0; m_unst = 0; m_bit = 0;
        chk("R1 bit_out", bit_out, 0);
        chk("R1 bit_valid", bit_valid, 0);
        chk("R1 unstable", unstable, 0);
        chk("R1 order", order_o, 0);
        chk("R1 rate_sel", rate_sel, 1);
    endtask

    task automatic t_third_dc();
        for (int i = 0; i < 300; i++) step(1, FS / 4, 0, 0, "R4 third dc");
        for (int i = 0; i < 200; i++) step(1, rnd(), 0, 0, "R4 third random");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 60; i++) step(i % 3 != 0, rnd(), 0, 0, "R2 gaps");
    endtask

    task automatic t_mode_ignored();
        for (int i = 0; i < 20; i++) step(1, rnd(), 1, 0, "R6 ignored");
        chk("R6 order stays third", order_o, 0);
    endtask

    task automatic t_mode_switch();
        step(0, 0, 1, 0, "R7 switch idle");
        chk("R5 fifth selected", order_o, 1);
        chk("R5 rate 64x", rate_sel, 0);
        for (int i = 0; i < 300; i++) step(1, rnd(), 1, 0, "R5 fifth random");
    endtask

    task automatic t_mute();
        for (int i = 0; i < 80; i++) step(1, (i % 2) ? FS - 1 : -FS, 1, 1, "R8 muted");
        step(1, rnd(), 0, 1, "R7 switch muted");
        chk("R7 third after muted switch", order_o, 0);
        for (int i = 0; i < 80; i++) step(1, rnd(), 0, 0, "R7 after clear");
    endtask

    task automatic t_overload();
        step(0, 0, 1, 0, "R9 to fifth");
        for (int i = 0; i < 400; i++) step(1, FS - 1, 1, 0, "R9 overload");
        for (int i = 0; i < 100; i++) step(1, (i % 8 < 4) ? -FS : FS - 1, 1, 0, "R9 swing");
        for (int i = 0; i < 100; i++) step(1, rnd(), 1, 0, "R9 recover");
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_third_dc();
        t_gaps();
        t_mode_ignored();
        t_mode_switch();
        t_mute();
        t_overload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule